// File: doc/BRIEF.md
# Dual-Channel Memory Fill Engine

This block holds two independent fill channels behind a small register bus. Each channel has its own start address, end address, fill value and pattern-width selection. Software programs a channel and then sets its trigger bit. The channel then paints the pattern over the half-open range [start, end) through a single byte-addressed memory write port. While a fill runs, the trigger bit reads back as one. When the fill ends, the trigger bit drops, the finished bit rises and the channel pulses its own interrupt line.

Three pattern widths are offered: 16-bit halfwords, 32-bit words, and a packed 3-byte colour pattern written one byte at a time, which may sit at any alignment. A start address of zero is treated as "no fill". The handshake still completes and the finished bit still rises, but no memory is touched and no interrupt is raised. Both channels share the one write port, and channel 0 always wins it.

Top module: `dual_fill_engine`

## Requirements
- R1: After reset every register reads zero, `memValid` is low and both `irq` lines are low.
- R2: `regAddr[2]` selects the channel and `regAddr[1:0]` selects the register: 0 is start, 1 is end (both ADDR_W bits wide, upper bits read zero), 2 is the 32-bit fill value, and 3 is control. Control bit 0 is trigger/busy, bit 1 selects the 3-byte mode, bit 2 selects the word mode and bit 3 is finished (read-only). Written fields read back unchanged.
- R3: With bits 1 and 2 both clear, the channel writes `value[15:0]` as halfwords (`memSize`=1) at start, start+2, … while the address is below end.
- R4: With bit 2 set and bit 1 clear, the channel writes `value` as words (`memSize`=2) at start, start+4, … while the address is below end.
- R5: With bit 1 set, bit 2 is ignored. Each step writes single bytes (`memSize`=0): `value[7:0]` at p, `value[15:8]` at p+1 and `value[23:16]` at p+2, in that order. p then advances by 3. A step that begins below end always writes all three bytes.
- R6: A write is accepted on each rising edge where `memValid` and `memReady` are both high, so the engine issues one write per cycle. While `memReady` is low, the request is held unchanged. Memory data is little-endian: `memData[7:0]` goes to `memAddr`.
- R7: On the edge that accepts a channel's last write, that channel's trigger bit clears and its finished bit sets. Its `irq` line is high for the following cycle.
- R8: A trigger with start equal to zero issues no writes and raises no interrupt. The trigger bit reads zero and the finished bit reads one from the next cycle on.
- R9: A trigger with nonzero start and start ≥ end issues no writes. It sets finished and pulses `irq` in the next cycle.
- R10: Any register write to a channel while it is busy is dropped, including a new trigger.
- R11: When both channels are busy, channel 0 owns the write port until its fill ends. Channel 1 resumes afterwards.
- R12: Triggering a fill clears the finished bit for the duration of the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word index (channel, register) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| memValid | output | 1 | Write request valid |
| memAddr | output | ADDR_W | Byte address of the write |
| memData | output | 32 | Write data, low bytes used |
| memSize | output | 2 | 0 byte, 1 halfword, 2 word |
| memReady | input | 1 | Memory accepts the write this cycle |
| irq | output | 2 | Per-channel completion pulse |

## Verification
The bench builds the engine with ADDR_W=8. This makes the whole 256-byte address space small enough for a shadow memory that is compared in full after every fill, so any stray write outside the range is caught. The sweep uses six start offsets, which cover every alignment modulo 3 and 4. It crosses them with lengths from 0 to 9 in all three widths, on both channels, with the ready signal both steady and randomly stalled. This reaches the overshooting last step, the empty range and the mode-priority case. Directed runs add the zero-start handshake, dropped writes during a busy fill, and a channel 0 pre-emption of a running channel 1.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam int NUM_CH = 2;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int REG_AW = CH_W + 2;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } memSize_e;

  typedef struct packed {
    logic [NUM_CH-1:0] load;
    logic [NUM_CH-1:0] grant;
    logic [NUM_CH-1:0] step;
  } dpStrobe_t;
endpackage

// File: rtl/fe_ctrl.sv
module fe_ctrl
  import fe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [REG_AW-1:0]              regAddr,
  input  logic [31:0]                    regWrData,
  output logic [31:0]                    regRdData,
  input  logic                           memReady,
  input  logic [NUM_CH-1:0]              lastBeat,
  output dpStrobe_t                      strobe,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  startAddr,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  endAddr,
  output logic [NUM_CH-1:0][31:0]        fillVal,
  output logic [NUM_CH-1:0]              mode24,
  output logic [NUM_CH-1:0]              mode32,
  output logic                           memValid,
  output logic [NUM_CH-1:0]              irq
);
  logic [NUM_CH-1:0][ADDR_W-1:0] startR, endR;
  logic [NUM_CH-1:0][31:0] valR;
  logic [NUM_CH-1:0] m24R, m32R, busyR, doneR, irqR;
  logic [NUM_CH-1:0] wrHit, trig, runs, gnt, stepNow;
  logic [CH_W-1:0] selCh;
  logic [1:0] selIdx;
  logic taken;

  assign selCh = regAddr[REG_AW-1:2];
  assign selIdx = regAddr[1:0];

  always_comb begin
    taken = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      gnt[c] = busyR[c] && !taken;
      taken = taken | busyR[c];
      stepNow[c] = gnt[c] && memReady;
      wrHit[c] = regWrEn && (selCh == CH_W'(c)) && !busyR[c];
      trig[c] = wrHit[c] && (selIdx == 2'd3) && regWrData[0];
      runs[c] = trig[c] && (startR[c] != '0) && (startR[c] < endR[c]);
    end
  end

  assign strobe.load = runs;
  assign strobe.grant = gnt;
  assign strobe.step = stepNow;
  assign memValid = |busyR;
  assign irq = irqR;
  assign startAddr = startR;
  assign endAddr = endR;
  assign fillVal = valR;
  assign mode24 = m24R;
  assign mode32 = m32R;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startR <= '0; endR <= '0; valR <= '0;
      m24R <= '0; m32R <= '0; busyR <= '0; doneR <= '0; irqR <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        irqR[c] <= 1'b0;
        if (wrHit[c]) begin
          case (selIdx)
            2'd0: startR[c] <= regWrData[ADDR_W-1:0];
            2'd1: endR[c] <= regWrData[ADDR_W-1:0];
            2'd2: valR[c] <= regWrData;
            default: begin
              m24R[c] <= regWrData[1];
              m32R[c] <= regWrData[2];
              if (trig[c]) begin
                if (runs[c]) begin
                  busyR[c] <= 1'b1;
                  doneR[c] <= 1'b0;
                end else begin
                  doneR[c] <= 1'b1;
                  irqR[c] <= (startR[c] != '0);
                end
              end
            end
          endcase
        end
        if (stepNow[c] && lastBeat[c]) begin
          busyR[c] <= 1'b0;
          doneR[c] <= 1'b1;
          irqR[c] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (selIdx)
      2'd0: regRdData[ADDR_W-1:0] = startR[selCh];
      2'd1: regRdData[ADDR_W-1:0] = endR[selCh];
      2'd2: regRdData = valR[selCh];
      default: regRdData[3:0] = {doneR[selCh], m32R[selCh], m24R[selCh], busyR[selCh]};
    endcase
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R7: a completion pulse always comes with finished set and busy clear
    a_r7_irq_done: assert property (@(posedge clk) disable iff (!rstN)
      irqR[c] |-> (doneR[c] && !busyR[c]));
    // R7: busy never drops without a pulse
    a_r7_busy_fall: assert property (@(posedge clk) disable iff (!rstN)
      $fell(busyR[c]) |-> irqR[c]);
    // R10: configuration frozen while busy
    a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
      busyR[c] |=> ($stable(startR[c]) && $stable(endR[c]) && $stable(valR[c])
                    && $stable(m24R[c]) && $stable(m32R[c])));
    // R8: zero start completes the handshake without running
    a_r8_zero_start: assert property (@(posedge clk) disable iff (!rstN)
      (trig[c] && startR[c] == '0) |=> (doneR[c] && !busyR[c] && !irqR[c]));
  end
endmodule

// File: rtl/fe_dp.sv
module fe_dp
  import fe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  startAddr,
  input  logic [NUM_CH-1:0][ADDR_W-1:0]  endAddr,
  input  logic [NUM_CH-1:0][31:0]        fillVal,
  input  logic [NUM_CH-1:0]              mode24,
  input  logic [NUM_CH-1:0]              mode32,
  output logic [NUM_CH-1:0]              lastBeat,
  output logic [ADDR_W-1:0]              memAddr,
  output logic [31:0]                    memData,
  output logic [1:0]                     memSize
);
  logic [NUM_CH-1:0][ADDR_W-1:0] beatAddr;
  logic [NUM_CH-1:0][31:0] beatData;
  logic [NUM_CH-1:0][1:0] beatSize;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [ADDR_W-1:0] ptr;
    logic [1:0] sub;
    logic [2:0] stepBytes;
    logic [ADDR_W:0] nextBase;
    logic lb;
    logic [31:0] bd;
    memSize_e bs;

    always_comb begin
      if (mode24[c]) stepBytes = 3'd3;
      else if (mode32[c]) stepBytes = 3'd4;
      else stepBytes = 3'd2;
      nextBase = {1'b0, ptr} + (ADDR_W+1)'(stepBytes);
      lb = (!mode24[c] || sub == 2'd2) && (nextBase >= {1'b0, endAddr[c]});
      if (mode24[c]) begin
        bd = {24'd0, fillVal[c][{sub, 3'b000} +: 8]};
        bs = SZ_BYTE;
      end else if (mode32[c]) begin
        bd = fillVal[c];
        bs = SZ_WORD;
      end else begin
        bd = {16'd0, fillVal[c][15:0]};
        bs = SZ_HALF;
      end
    end

    assign lastBeat[c] = lb;
    assign beatAddr[c] = ptr + ADDR_W'(sub);
    assign beatData[c] = bd;
    assign beatSize[c] = bs;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ptr <= '0;
        sub <= '0;
      end else if (strobe.load[c]) begin
        ptr <= startAddr[c];
        sub <= '0;
      end else if (strobe.step[c]) begin
        if (mode24[c] && sub != 2'd2) begin
          sub <= sub + 2'd1;
        end else begin
          ptr <= nextBase[ADDR_W-1:0];
          sub <= '0;
        end
      end
    end

    // R3: the write pointer of a granted channel stays inside [start, end)
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rstN)
      strobe.grant[c] |-> (ptr >= startAddr[c] && ptr < endAddr[c]));
    // R5: byte index of the 3-byte step never reaches 3
    a_r5_sub_range: assert property (@(posedge clk) disable iff (!rstN)
      sub != 2'd3);
  end

  always_comb begin
    memAddr = '0;
    memData = '0;
    memSize = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobe.grant[c]) begin
        memAddr = memAddr | beatAddr[c];
        memData = memData | beatData[c];
        memSize = memSize | beatSize[c];
      end
    end
  end

  // R6: a stalled request is held while the same channel keeps the port
  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    ((|strobe.grant) && !(|strobe.step)) |=>
      ((strobe.grant != $past(strobe.grant)) ||
       (memAddr == $past(memAddr) && memData == $past(memData) && memSize == $past(memSize))));
endmodule

// File: rtl/dual_fill_engine.sv
module dual_fill_engine
  import fe_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memValid,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic [1:0]        memSize,
  input  logic              memReady,
  output logic [1:0]        irq
);
  dpStrobe_t strobe;
  logic [NUM_CH-1:0][ADDR_W-1:0] startAddr, endAddr;
  logic [NUM_CH-1:0][31:0] fillVal;
  logic [NUM_CH-1:0] mode24, mode32, lastBeat;

  fe_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReady(memReady),
    .lastBeat(lastBeat), .strobe(strobe), .startAddr(startAddr),
    .endAddr(endAddr), .fillVal(fillVal), .mode24(mode24), .mode32(mode32),
    .memValid(memValid), .irq(irq)
  );

  fe_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .endAddr(endAddr), .fillVal(fillVal), .mode24(mode24), .mode32(mode32),
    .lastBeat(lastBeat), .memAddr(memAddr), .memData(memData), .memSize(memSize)
  );
endmodule

// File: tb/sim_dual_fill_engine.sv
module sim_dual_fill_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memValid;
  logic [AW-1:0] memAddr;
  logic [31:0] memData;
  logic [1:0] memSize;
  logic memReady = 1'b0;
  logic [1:0] irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_fill_engine #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memValid(memValid),
    .memAddr(memAddr), .memData(memData), .memSize(memSize),
    .memReady(memReady), .irq(irq)
  );

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] benchMem [0:255];
  logic [7:0] expMem [0:255];
  int wrCount = 0;
  int irqCount [2];
  int readyMode = 0;
  logic [7:0] lfsr = 8'h5A;
  bit irqTimingOn = 0;
  bit prevAccept = 0;
  int regLo = 0, regHi = 0, otherLo = 0, otherHi = 0;
  int regHits = 0, prioViol = 0, regTarget = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    irqCount[0] = 0;
    irqCount[1] = 0;
    forever begin
      @(negedge clk);
      if (readyMode == 0) memReady = 1'b1;
      else begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        memReady = lfsr[0] | lfsr[3];
      end
      if (rstN) begin
        for (int c = 0; c < 2; c++) begin
          if (irq[c]) begin
            irqCount[c]++;
            if (irqTimingOn) chk(prevAccept, "R7", "irq follows last write", 0, 1);
          end
        end
        if (memValid && memReady) begin
          wrCount++;
          prevAccept = 1;
          benchMem[memAddr] = memData[7:0];
          if (memSize >= 2'd1) benchMem[8'(memAddr + 1)] = memData[15:8];
          if (memSize == 2'd2) begin
            benchMem[8'(memAddr + 2)] = memData[23:16];
            benchMem[8'(memAddr + 3)] = memData[31:24];
          end
          if (int'(memAddr) >= regLo && int'(memAddr) < regHi) regHits++;
          else if (int'(memAddr) >= otherLo && int'(memAddr) < otherHi
                   && regHits > 0 && regHits < regTarget) prioViol++;
        end else prevAccept = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regAddr = 3'(a);
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    regAddr = 3'(a);
    #1 d = regRdData;
  endtask

  task automatic waitDone(input int ch);
    logic [31:0] d;
    d = '0;
    while (!d[3]) rd(ch*4 + 3, d);
  endtask

  task automatic clearAll();
    for (int i = 0; i < 256; i++) begin
      benchMem[i] = 8'h00;
      expMem[i] = 8'h00;
    end
    wrCount = 0;
    irqCount[0] = 0;
    irqCount[1] = 0;
    regHits = 0;
    prioViol = 0;
  endtask

  // mode: 0 halfword, 1 word, 2 three-byte; returns number of writes
  function automatic int expFill(input int mode, input int s, input int e,
                                 input logic [31:0] v);
    int n = 0;
    if (s == 0) return 0;
    for (int p = s; p < e; p += (mode == 2 ? 3 : (mode == 1 ? 4 : 2))) begin
      if (mode == 2) begin
        expMem[p] = v[7:0]; expMem[p+1] = v[15:8]; expMem[p+2] = v[23:16];
        n += 3;
      end else if (mode == 1) begin
        expMem[p] = v[7:0]; expMem[p+1] = v[15:8];
        expMem[p+2] = v[23:16]; expMem[p+3] = v[31:24];
        n++;
      end else begin
        expMem[p] = v[7:0]; expMem[p+1] = v[15:8];
        n++;
      end
    end
    return n;
  endfunction

  function automatic int memDiffs();
    int n = 0;
    for (int i = 0; i < 256; i++) if (benchMem[i] !== expMem[i]) n++;
    return n;
  endfunction

  initial begin
    logic [31:0] d;
    int nw, nw1, ch;
    logic [31:0] val;
    string req;
    repeat (3) @(negedge clk);
    chk(memValid == 1'b0, "R1", "memValid in reset", memValid, 0);
    rstN = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d == 0, "R1", "register after reset", d, 0);
    end
    chk(irq == 2'b00, "R1", "irq after reset", irq, 0);

    // R2 register map readback
    wr(4, 32'h1FF); rd(4, d); chk(d == 32'hFF, "R2", "start truncation", d, 32'hFF);
    wr(4, 32'h33); wr(5, 32'h44); wr(6, 32'hA5A51234); wr(7, 32'h6);
    rd(4, d); chk(d == 32'h33, "R2", "start readback", d, 32'h33);
    rd(5, d); chk(d == 32'h44, "R2", "end readback", d, 32'h44);
    rd(6, d); chk(d == 32'hA5A51234, "R2", "value readback", d, 32'hA5A51234);
    rd(7, d); chk(d == 32'h6, "R2", "control readback", d, 32'h6);
    rd(0, d); chk(d == 0, "R2", "other channel untouched", d, 0);

    // R8 zero start
    clearAll();
    wr(4, 32'h0); wr(7, 32'h5);
    repeat (2) @(negedge clk);
    rd(7, d); chk(d == 32'hC, "R8", "control after zero-start trigger", d, 32'hC);
    chk(wrCount == 0, "R8", "writes on zero start", wrCount, 0);
    chk(irqCount[1] == 0, "R8", "irq on zero start", irqCount[1], 0);

    // sweep: R3 R4 R5 R6 R7 R9
    for (int mode = 0; mode < 3; mode++) begin
      for (int s = 0; s < 6; s++) begin
        for (int len = 0; len < 10; len++) begin
          ch = (s + len) % 2;
          val = {8'(len*17 + 1), 8'(s*29 + 3), 8'(mode*71 + 5), 8'(len + s + mode)};
          req = (len == 0) ? "R9" : (mode == 0 ? "R3" : (mode == 1 ? "R4" : "R5"));
          readyMode = len % 2;
          clearAll();
          nw = expFill(mode, 8 + s, 8 + s + len, val);
          wr(ch*4 + 0, 32'(8 + s));
          wr(ch*4 + 1, 32'(8 + s + len));
          wr(ch*4 + 2, val);
          irqTimingOn = (len > 0);
          wr(ch*4 + 3, 32'h1 | (mode == 1 ? 32'h4 : 32'h0)
                       | (mode == 2 ? (32'h2 | ((s % 2) ? 32'h4 : 32'h0)) : 32'h0));
          waitDone(ch);
          irqTimingOn = 0;
          chk(memDiffs() == 0, req, "memory image mismatches", memDiffs(), 0);
          chk(wrCount == nw, "R6", "write count", wrCount, nw);
          chk(irqCount[ch] == 1 && irqCount[1-ch] == 0, "R7", "irq pulses",
              irqCount[ch] + 16*irqCount[1-ch], 1);
          rd(ch*4 + 3, d);
          chk(d[3] == 1'b1 && d[0] == 1'b0, "R7", "trigger/finished after fill",
              d[3:0], {1'b1, 3'bxx0});
        end
      end
    end
    readyMode = 0;

    // R10 / R12: writes during a busy fill are dropped
    clearAll();
    nw = expFill(0, 60, 90, 32'h0000BEEF);
    wr(0, 60); wr(1, 90); wr(2, 32'h0000BEEF); wr(3, 32'h1);
    rd(3, d); chk(d[3:0] == 4'b0001, "R12", "busy with finished cleared", d[3:0], 4'b0001);
    wr(0, 70); wr(2, 32'h1234); wr(3, 32'h5);
    waitDone(0);
    rd(0, d); chk(d == 60, "R10", "start unchanged", d, 60);
    rd(2, d); chk(d == 32'hBEEF, "R10", "value unchanged", d, 32'hBEEF);
    rd(3, d); chk(d[2:0] == 3'b000, "R10", "mode unchanged", d[2:0], 0);
    chk(memDiffs() == 0, "R10", "memory image mismatches", memDiffs(), 0);
    chk(wrCount == nw, "R10", "write count", wrCount, nw);
    chk(irqCount[0] == 1, "R10", "single completion", irqCount[0], 1);

    // R11: channel 0 pre-empts a running channel 1
    clearAll();
    nw1 = expFill(0, 40, 60, 32'h00007788);
    nw = expFill(1, 100, 116, 32'hCAFEF00D);
    regLo = 100; regHi = 116; regTarget = nw; otherLo = 40; otherHi = 60;
    wr(4, 40); wr(5, 60); wr(6, 32'h7788);
    wr(0, 100); wr(1, 116); wr(2, 32'hCAFEF00D);
    wr(7, 32'h1);
    wr(3, 32'h5);
    waitDone(0);
    waitDone(1);
    chk(prioViol == 0, "R11", "channel 1 writes inside channel 0 run", prioViol, 0);
    chk(regHits == nw, "R11", "channel 0 writes", regHits, nw);
    chk(memDiffs() == 0, "R11", "memory image mismatches", memDiffs(), 0);
    chk(wrCount == nw + nw1, "R11", "total writes", wrCount, nw + nw1);
    chk(irqCount[0] == 1 && irqCount[1] == 1, "R11", "both irqs",
        irqCount[0] + 16*irqCount[1], 17);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule